// File: doc/BRIEF.md
# Calendar Clock with Exact-Match Alarm

This block is a real-time clock core that keeps the date and the time of day in packed BCD bytes: seconds, minutes, hours, day of month, month and a two-digit year standing for 2000 to 2099. It also keeps a day-of-week count that runs from 0 to 6. A prescaler divides the 32.768 kHz input clock down to one update per second. The day field rolls over according to the length of the month, and leap years are taken into account.

Software reaches the block through a byte-wide register port with combinational reads. Through it, software sets the time, loads a six-field alarm, starts and stops the clock, and enables two interrupt outputs. The alarm has no wildcard fields: it fires only when all six time fields equal the alarm bytes. A BUSY status bit is high during the single clock cycle before each update, so software can time its accesses away from the update. Event flags for the second, minute, hour, day and alarm stick until software writes a one to them. A power-up flag marks a cold reset.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time reads 00:00:00, the day 0x01, the month 0x01, the year 0x00 and the week 0. All alarm bytes, the control register and the interrupt-enable register read 0x00. Status reads 0x80.
- R2: Register offsets, with reads valid in the same cycle: seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14, week 0x18. The alarm bytes for seconds through year sit at 0x20 to 0x34 in steps of 4. Control is at 0x40, status at 0x44 and interrupt enable at 0x48. Any other offset, 0x1C included, reads 0x00.
- R3: Control bit 0 is the run bit. While it is set, the seconds field advances once every CLK_DIV clocks. While it is clear, the time and the prescaler are frozen. Status bit 1 reads the run bit.
- R4: Status bit 0 (BUSY) is high only during the one clock that ends in a time update. It is never high while the clock is stopped.
- R5: Seconds and minutes wrap from 0x59 to 0x00, and each wrap carries into the next field. Hours wrap from 0x23 to 0x00 and carry into the day.
- R6: The day wraps to 0x01 after the last day of the month. Months 0x04, 0x06, 0x09 and 0x11 have 30 days. February has 29 days when the year is divisible by 4 (0x00 included) and 28 days otherwise. All other months have 31 days. Month 0x12 wraps to 0x01 and carries into the year, and the year wraps from 0x99 to 0x00. The week counts 0 to 6 and advances with the day.
- R7: On each update, status bit 2 is set. Bit 3 is set when the seconds wrap, bit 4 when the minutes wrap and bit 5 when the hours wrap.
- R8: Status bit 6 is set one clock after an update that makes all six time fields equal the six alarm bytes. A mismatch in any single field keeps it clear.
- R9: Writing status clears each of bits 7 to 2 that is written as one. Bits written as zero are unchanged. A new event set in the same cycle wins over the clear. Bits 1 and 0 are read-only.
- R10: Status bit 7 is set by reset and stays set until software writes a one to it.
- R11: A write to a time register takes effect at the next clock edge. A seconds write restarts the prescaler, so the next update comes CLK_DIV clocks later. A time write in the update cycle cancels that update.
- R12: Interrupt-enable bit 2 gates status bit 2 onto irq_timer, and bit 3 gates status bit 6 onto irq_alarm. No other bits of that register are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe, one byte per clock |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_timer | output | 1 | Enabled one-second event |
| irq_alarm | output | 1 | Enabled alarm event |

## Verification
A wrong prescaler count or a lost carry shows at the ports within one update period. It appears as a seconds or date byte that differs from the reference model, or as a BUSY bit that lands in the wrong cycle. A faulty month-length or leap decision shows only at the update that crosses a month end, so the bench drives the time to just before each kind of boundary and compares every readable byte on every clock. A wrong alarm comparison or status-clear path shows one clock after the update concerned, as a mismatched status bit 6 or irq_alarm.

// File: rtl/rtc_pkg.sv
// Shared constants and BCD helpers for the calendar clock core.
// Assumes all time fields hold valid packed BCD; invalid codes are not corrected.
package rtc_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int NUM_ALARM  = 6;
    localparam int IDX_W      = 3;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;
    localparam int F_WEEK = 6;

    localparam logic [7:0] ADDR_CTRL = 8'h40;
    localparam logic [7:0] ADDR_STAT = 8'h44;
    localparam logic [7:0] ADDR_IEN  = 8'h48;

    localparam int IE_TIMER = 2;
    localparam int IE_ALARM = 3;

    // Value a field restarts from after it wraps, also its reset value.
    function automatic logic [7:0] field_base(input int idx);
        return (idx == F_DAY || idx == F_MON) ? 8'h01 : 8'h00;
    endfunction

    // Increment a packed BCD byte by one.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    // Two-digit BCD year divisible by four (00 counts).
    function automatic logic leap_bcd(input logic [7:0] y);
        if (!y[4])
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    // Last valid day of a month, in BCD.
    function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return leap_bcd(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the input clock by DIV to pace the one-second update.
// Assumes DIV >= 2. busy_o is high in the last count, which is the update cycle.
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic busy_o
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == LAST);
    assign busy_o  = run_i && at_last;

    // Count while running; restart on request, hold while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart_i)
            cnt_q <= '0;
        else if (run_i)
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/rtc_calendar.sv
// Holds the seven BCD time fields and advances them with carries.
// Assumes at most one field write per clock; a write blocks the advance for that cycle.
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             advance_i,
    input  logic                             wr_en_i,
    input  logic [IDX_W-1:0]                 wr_idx_i,
    input  logic [7:0]                       wr_data_i,
    output logic [NUM_FIELDS-1:0][7:0]       now_o,
    output logic                             ev_sec_o,
    output logic                             ev_min_o,
    output logic                             ev_hour_o,
    output logic                             ev_day_o
);
    logic [NUM_FIELDS-1:0][7:0] cur;
    logic [NUM_FIELDS-1:0]      wraps;
    logic [NUM_FIELDS-1:0]      carry;

    // Detect the last value of each field.
    always_comb begin
        wraps          = '0;
        wraps[F_SEC]   = (cur[F_SEC]  == 8'h59);
        wraps[F_MIN]   = (cur[F_MIN]  == 8'h59);
        wraps[F_HOUR]  = (cur[F_HOUR] == 8'h23);
        wraps[F_DAY]   = (cur[F_DAY]  == month_last_day(cur[F_MON], cur[F_YEAR]));
        wraps[F_MON]   = (cur[F_MON]  == 8'h12);
        wraps[F_YEAR]  = (cur[F_YEAR] == 8'h99);
        wraps[F_WEEK]  = (cur[F_WEEK] == 8'h06);
    end

    // Ripple the increment request from seconds to year; week follows the day.
    always_comb begin
        carry        = '0;
        carry[F_SEC] = advance_i;
        for (int i = F_MIN; i <= F_YEAR; i++)
            carry[i] = carry[i-1] & wraps[i-1];
        carry[F_WEEK] = carry[F_DAY];
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam logic [7:0] BASE = field_base(g);
        logic [7:0] q;
        logic [7:0] nxt;

        // Next value of this field under an advance.
        always_comb begin
            if (!carry[g])
                nxt = q;
            else if (wraps[g])
                nxt = BASE;
            else
                nxt = bcd_inc(q);
        end

        // Field register: write has priority over advance.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= BASE;
            else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
                q <= wr_data_i;
            else
                q <= nxt;
        end

        assign cur[g] = q;
    end

    assign now_o     = cur;
    assign ev_sec_o  = carry[F_SEC];
    assign ev_min_o  = carry[F_MIN];
    assign ev_hour_o = carry[F_HOUR];
    assign ev_day_o  = carry[F_DAY];

endmodule

// File: rtl/rtc_alarm_bank.sv
// Stores the six alarm bytes and compares them with the current time.
// Assumes exact match on every field; there is no per-field mask.
module rtc_alarm_bank
    import rtc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [IDX_W-1:0]            wr_idx_i,
    input  logic [7:0]                  wr_data_i,
    input  logic [NUM_FIELDS-1:0][7:0]  now_i,
    output logic [NUM_ALARM-1:0][7:0]   alarm_o,
    output logic                        match_o
);
    logic [NUM_ALARM-1:0] eq;

    for (genvar g = 0; g < NUM_ALARM; g++) begin : g_alarm
        logic [7:0] q;

        // Alarm byte register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= 8'h00;
            else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
                q <= wr_data_i;
        end

        assign alarm_o[g] = q;
        assign eq[g]      = (q == now_i[g]);
    end

    assign match_o = &eq;

endmodule

// File: rtl/rtc_calendar_core.sv
// Calendar clock core: prescaler, BCD calendar, alarm bank, status and register port.
// Assumes clk is the 32.768 kHz clock and that one register access happens per clock.
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int CLK_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_timer,
    output logic       irq_alarm
);
    logic [IDX_W-1:0] idx;
    logic             time_sel;
    logic             alm_sel;
    logic             time_wr;
    logic             sec_wr;
    logic             alm_wr;
    logic             ctrl_wr;
    logic             stat_wr;
    logic             ien_wr;

    logic             run_q;
    logic             ien_timer_q;
    logic             ien_alarm_q;
    logic [7:2]       stat_q;
    logic             upd_q;

    logic             busy;
    logic             advance;
    logic             alm_match;
    logic             ev_sec;
    logic             ev_min;
    logic             ev_hour;
    logic             ev_day;
    logic [7:2]       stat_set;
    logic [7:2]       stat_clr;

    logic [NUM_FIELDS-1:0][7:0] now;
    logic [NUM_ALARM-1:0][7:0]  alm;

    // Address decode for the register port.
    assign idx      = reg_addr[4:2];
    assign time_sel = (reg_addr[7:5] == 3'b000) && (reg_addr[1:0] == 2'b00)
                      && (idx != IDX_W'(NUM_FIELDS));
    assign alm_sel  = (reg_addr[7:5] == 3'b001) && (reg_addr[1:0] == 2'b00)
                      && (idx < IDX_W'(NUM_ALARM));
    assign time_wr  = reg_wr && time_sel;
    assign sec_wr   = time_wr && (idx == IDX_W'(F_SEC));
    assign alm_wr   = reg_wr && alm_sel;
    assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
    assign stat_wr  = reg_wr && (reg_addr == ADDR_STAT);
    assign ien_wr   = reg_wr && (reg_addr == ADDR_IEN);

    rtc_prescaler #(
        .DIV       (CLK_DIV)
    ) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_q),
        .restart_i (sec_wr),
        .busy_o    (busy)
    );

    // A time write in the update cycle cancels the update.
    assign advance = busy && !time_wr;

    rtc_calendar u_calendar (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (advance),
        .wr_en_i   (time_wr),
        .wr_idx_i  (idx),
        .wr_data_i (reg_wdata),
        .now_o     (now),
        .ev_sec_o  (ev_sec),
        .ev_min_o  (ev_min),
        .ev_hour_o (ev_hour),
        .ev_day_o  (ev_day)
    );

    rtc_alarm_bank u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (alm_wr),
        .wr_idx_i  (idx),
        .wr_data_i (reg_wdata),
        .now_i     (now),
        .alarm_o   (alm),
        .match_o   (alm_match)
    );

    // Control and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            ien_timer_q <= 1'b0;
            ien_alarm_q <= 1'b0;
        end else begin
            if (ctrl_wr)
                run_q <= reg_wdata[0];
            if (ien_wr) begin
                ien_timer_q <= reg_wdata[IE_TIMER];
                ien_alarm_q <= reg_wdata[IE_ALARM];
            end
        end
    end

    // Event sources and write-one-to-clear mask for the sticky status bits.
    assign stat_set = {1'b0, upd_q && alm_match, ev_day, ev_hour, ev_min, ev_sec};
    assign stat_clr = stat_wr ? reg_wdata[7:2] : 6'b0;

    // Sticky status bits; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 6'b10_0000;
            upd_q  <= 1'b0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            upd_q  <= advance;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = 8'h00;
        if (time_sel)
            reg_rdata = now[idx];
        else if (alm_sel)
            reg_rdata = alm[idx];
        else begin
            case (reg_addr)
                ADDR_CTRL: reg_rdata = {7'b0, run_q};
                ADDR_STAT: reg_rdata = {stat_q, run_q, busy};
                ADDR_IEN:  reg_rdata = {4'b0, ien_alarm_q, ien_timer_q, 2'b0};
                default:   reg_rdata = 8'h00;
            endcase
        end
    end

    assign irq_timer = stat_q[2] && ien_timer_q;
    assign irq_alarm = stat_q[6] && ien_alarm_q;

endmodule

// File: rtl/rtc_core_checker.sv
// Temporal properties of the calendar clock core, attached by bind.
module rtc_core_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic       busy,
    input logic       advance,
    input logic       time_wr,
    input logic       reg_wr,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] sec,
    input logic [7:0] min,
    input logic [7:0] hour,
    input logic       alm_flag,
    input logic       pwr_flag,
    input logic       alm_match
);
    AST_BUSY_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R4

    AST_STOP_FREEZES_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !time_wr) |=> ($stable(sec) && $stable(min) && $stable(hour))); // R3

    AST_SEC_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !time_wr) |=> $stable(sec)); // R11

    AST_DAY_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !time_wr && hour == 8'h23 && min == 8'h59 && sec == 8'h59)
        |=> (hour == 8'h00 && min == 8'h00 && sec == 8'h00)); // R5

    AST_ALARM_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> $past(alm_match)); // R8

    AST_PWRUP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_flag && !(reg_wr && reg_addr == 8'h44 && reg_wdata[7])) |=> pwr_flag); // R10

endmodule

bind rtc_calendar_core rtc_core_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .busy      (busy),
    .advance   (advance),
    .time_wr   (time_wr),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sec       (now[0]),
    .min       (now[1]),
    .hour      (now[2]),
    .alm_flag  (stat_q[6]),
    .pwr_flag  (stat_q[7]),
    .alm_match (alm_match)
);

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
    localparam int TCK  = 10;
    localparam int DIV  = 8;
    localparam int WDOG = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_timer;
    logic       irq_alarm;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    rtc_calendar_core #(.CLK_DIV(DIV)) u_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_timer(irq_timer), .irq_alarm(irq_alarm)
    );

    always #(TCK/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_t[7];
    int m_alm[6];
    int m_run, m_ien, m_stat, m_cnt, m_upd;

    function automatic int to_bcd(int v); return (v / 10) * 16 + v % 10; endfunction
    function automatic int from_bcd(int v); return (v >> 4) * 10 + (v & 15); endfunction
    function automatic int days_in(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int m_busy(); return (m_run != 0 && m_cnt == DIV - 1) ? 1 : 0; endfunction

    function automatic int m_read(logic [7:0] a);
        if (a[7:5] == 0 && a[1:0] == 0 && a[4:2] != 7) return to_bcd(m_t[a[4:2]]);
        if (a[7:5] == 1 && a[1:0] == 0 && a[4:2] < 6) return m_alm[a[4:2]];
        if (a == 8'h40) return m_run;
        if (a == 8'h44) return m_stat | (m_run << 1) | m_busy();
        if (a == 8'h48) return m_ien;
        return 0;
    endfunction

    function automatic string tag_for(logic [7:0] a);
        if (a < 8'h1C) return "R6";
        if (a >= 8'h20 && a < 8'h38) return "R8";
        if (a == 8'h40) return "R3";
        if (a == 8'h44) return "R9";
        if (a == 8'h48) return "R12";
        return "R2";
    endfunction

    int set_bits, clr_bits, hit, tick, twr, idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_t = '{0, 0, 0, 1, 1, 0, 0};
            foreach (m_alm[i]) m_alm[i] = 0;
            m_run = 0; m_ien = 0; m_stat = 8'h80; m_cnt = 0; m_upd = 0;
        end else begin
            idx  = reg_addr[4:2];
            twr  = (reg_wr && reg_addr[7:5] == 0 && reg_addr[1:0] == 0 && idx != 7) ? 1 : 0;
            tick = (m_busy() != 0 && twr == 0) ? 1 : 0;
            hit  = m_upd;
            for (int i = 0; i < 6; i++) if (m_alm[i] != to_bcd(m_t[i])) hit = 0;
            set_bits = hit ? 8'h40 : 0;
            if (tick) begin
                set_bits |= 8'h04;
                m_t[0]++;
                if (m_t[0] == 60) begin
                    m_t[0] = 0; set_bits |= 8'h08; m_t[1]++;
                    if (m_t[1] == 60) begin
                        m_t[1] = 0; set_bits |= 8'h10; m_t[2]++;
                        if (m_t[2] == 24) begin
                            m_t[2] = 0; set_bits |= 8'h20;
                            m_t[6] = (m_t[6] + 1) % 7;
                            m_t[3]++;
                            if (m_t[3] > days_in(m_t[4], m_t[5])) begin
                                m_t[3] = 1; m_t[4]++;
                                if (m_t[4] > 12) begin m_t[4] = 1; m_t[5] = (m_t[5] + 1) % 100; end
                            end
                        end
                    end
                end
            end
            clr_bits = (reg_wr && reg_addr == 8'h44) ? (reg_wdata & 8'hFC) : 0;
            m_stat = (m_stat & ~clr_bits & 8'hFC) | set_bits;
            if (twr) m_t[idx] = from_bcd(reg_wdata);
            if (reg_wr && reg_addr[7:5] == 1 && reg_addr[1:0] == 0 && idx < 6) m_alm[idx] = reg_wdata;
            if (twr && idx == 0) m_cnt = 0;
            else if (m_run) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
            if (reg_wr && reg_addr == 8'h40) m_run = reg_wdata[0];
            if (reg_wr && reg_addr == 8'h48) m_ien = reg_wdata & 8'h0C;
            m_upd = tick;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison of the read port and both interrupts against the model.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            chk(tag_for(reg_addr), reg_rdata, 8'(m_read(reg_addr)));
            chk("R12 timer", {7'b0, irq_timer}, 8'((m_stat >> 2) & (m_ien >> 2) & 1));
            chk("R12 alarm", {7'b0, irq_alarm}, 8'((m_stat >> 6) & (m_ien >> 3) & 1));
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] mask, logic [7:0] exp, string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata & mask, exp);
    endtask

    task automatic set_time(logic [7:0] y, logic [7:0] mo, logic [7:0] d,
                            logic [7:0] h, logic [7:0] mi, logic [7:0] s);
        wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d); wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(TCK * WDOG);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state, R2 unmapped offsets
        rd(8'h44, 8'hFF, 8'h80, "R1 status");
        rd(8'h00, 8'hFF, 8'h00, "R1 seconds");
        rd(8'h0C, 8'hFF, 8'h01, "R1 day");
        rd(8'h10, 8'hFF, 8'h01, "R1 month");
        rd(8'h20, 8'hFF, 8'h00, "R1 alarm");
        rd(8'h40, 8'hFF, 8'h00, "R1 control");
        rd(8'h1C, 8'hFF, 8'h00, "R2 gap");
        rd(8'h3C, 8'hFF, 8'h00, "R2 unmapped");
        // R10 / R9: zero writes do nothing, one clears power-up
        wr(8'h44, 8'h00);
        rd(8'h44, 8'hFF, 8'h80, "R10 kept");
        wr(8'h44, 8'h80);
        rd(8'h44, 8'hFF, 8'h00, "R10 cleared");
        // Leap-day crossing, busy timing, events
        wr(8'h48, 8'hFF);
        rd(8'h48, 8'hFF, 8'h0C, "R12 enables");
        wr(8'h40, 8'h01);
        wr(8'h18, 8'h03);
        set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58);
        rd(8'h00, 8'hFF, 8'h58, "R11 write");
        idle(7);
        rd(8'h44, 8'hFF, 8'h03, "R4 busy");
        idle(1);
        rd(8'h00, 8'hFF, 8'h59, "R3 advance");
        rd(8'h44, 8'hFF, 8'h06, "R7 second event");
        chk("R12 irq_timer", {7'b0, irq_timer}, 8'h01);
        wr(8'h44, 8'h04);
        rd(8'h44, 8'hFF, 8'h02, "R9 clear");
        idle(7);
        rd(8'h08, 8'hFF, 8'h00, "R5 hour wrap");
        rd(8'h0C, 8'hFF, 8'h29, "R6 leap day");
        rd(8'h18, 8'hFF, 8'h04, "R6 week");
        rd(8'h44, 8'hFF, 8'h3E, "R7 all events");
        // Month-end cases
        set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); idle(8);
        rd(8'h10, 8'hFF, 8'h03, "R6 common Feb");
        rd(8'h0C, 8'hFF, 8'h01, "R6 common Feb day");
        set_time(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); idle(8);
        rd(8'h0C, 8'hFF, 8'h29, "R6 year 00 leap");
        set_time(8'h25, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59); idle(8);
        rd(8'h10, 8'hFF, 8'h05, "R6 30-day month");
        set_time(8'h25, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59); idle(8);
        rd(8'h0C, 8'hFF, 8'h31, "R6 31-day month");
        set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59); idle(8);
        rd(8'h14, 8'hFF, 8'h00, "R6 year wrap");
        rd(8'h10, 8'hFF, 8'h01, "R6 month wrap");
        // Alarm exact match
        wr(8'h44, 8'hFC);
        wr(8'h20, 8'h10); wr(8'h24, 8'h30); wr(8'h28, 8'h12);
        wr(8'h2C, 8'h15); wr(8'h30, 8'h06); wr(8'h34, 8'h25);
        set_time(8'h25, 8'h06, 8'h15, 8'h12, 8'h30, 8'h09); idle(8);
        rd(8'h44, 8'h40, 8'h00, "R8 not yet");
        idle(1);
        rd(8'h44, 8'h40, 8'h40, "R8 alarm");
        chk("R12 irq_alarm", {7'b0, irq_alarm}, 8'h01);
        wr(8'h44, 8'h40);
        rd(8'h44, 8'h40, 8'h00, "R9 alarm clear");
        wr(8'h34, 8'h26);
        set_time(8'h25, 8'h06, 8'h15, 8'h12, 8'h30, 8'h09); idle(9);
        rd(8'h44, 8'h40, 8'h00, "R8 year mismatch");
        // Write during the update cycle cancels it
        set_time(8'h25, 8'h01, 8'h01, 8'h10, 8'h00, 8'h20);
        idle(7);
        wr(8'h04, 8'h11);
        rd(8'h00, 8'hFF, 8'h20, "R11 cancel");
        rd(8'h04, 8'hFF, 8'h11, "R11 minute");
        // Stop freezes time
        wr(8'h40, 8'h00);
        idle(20);
        rd(8'h00, 8'hFF, 8'h20, "R3 stopped");
        rd(8'h44, 8'h03, 8'h00, "R4 no busy stopped");
        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule